// File: doc/BRIEF.md
# SD Host Register and Interrupt Bank

This block is the software-visible register file of a simple SD card host controller. It sits on a 32-bit word register bus and holds the registers that the command engine and the data path work from: command word, command argument, configuration, power, a debug/mode word, a byte-count and block-count pair, four response words and an 11-bit status word. Two further offsets, for the timeout and the clock divider, accept writes and keep nothing. The data port offset keeps nothing either. Accesses to it are passed on as single-cycle pulses.

The status word is set by the host-side engines through a per-bit set input and cleared by software writing ones. A single level interrupt is derived from the busy, block and data status bits and is registered. Writing the block count computes the total transfer length for the data path. Writing the command word with its start bit raises a start pulse for the command engine. Reads return their data one cycle after the request. The data-port pulses carry no back-pressure: the data path must take or supply its word in the cycle of the pulse.

Top module: `sdh_regbank`

## Requirements
- R1: After reset, reads return 0x0000C60F for the debug/mode word at 0x34 and zero for every other offset. The `irq`, `xfer_bytes` and `cmd_go` outputs are low.
- R2: These registers read back what was written, taken from the low bits of the write data: argument at 0x04 (32 bits), power at 0x30 (bit 0), configuration at 0x38 (bits 10:0), byte count at 0x3C (32 bits) and block count at 0x50 (bits 8:0). Unstored upper bits read as zero.
- R3: A write to the command word at 0x00 stores bits 15:0 with bit 15 (start) forced to 0. `cmd_go` is high during the write cycle exactly when write-data bit 15 is 1.
- R4: A write to status at 0x20 clears each status bit whose write-data bit is 1. A status bit that `sts_set` raises in the same cycle stays set.
- R5: `irq` is high exactly when status bit 10, 9 or 8 was set in the previous cycle, so it follows a status change by one cycle.
- R6: A write to the debug/mode word at 0x34 with bits 3:0 equal to 0xF stores those four bits as 0. All other bits are stored as written.
- R7: A write to the block count loads `xfer_bytes` with the low 32 bits of (written block count, bits 8:0) times the current byte count. A later byte-count write leaves `xfer_bytes` unchanged.
- R8: Writes to 0x08 (timeout), 0x0C (clock divider), the response offsets and unmapped offsets change no register. Reads of 0x08, 0x0C and unmapped offsets return zero.
- R9: A write to the data port at 0x40 pulses `dport_wr` with `dport_wdata` equal to the write data. A read of 0x40 pulses `dport_rd` and returns `dport_rdata` as sampled in that cycle.
- R10: `rsp_load` captures `rsp_data` word i (bits 32i+31:32i) into the response word read at offset 0x10+4i, for i = 0 to 3.
- R11: `bus_rvalid` is high in the cycle after each read request and low otherwise. `bus_rdata` is zero when `bus_rvalid` is low.
- R12: `sts_set` bit 10 takes effect only when configuration bit 10 is 1, bit 9 only when configuration bit 8 is 1, and bit 8 only when configuration bit 4 is 1. Other status bits set unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Level interrupt |
| cmd_go | output | 1 | Command start pulse |
| cmd_word | output | 16 | Stored command word |
| cmd_arg | output | DATA_W | Stored command argument |
| cfg_word | output | 11 | Stored configuration |
| pwr_on | output | 1 | Card power enable |
| mode_word | output | DATA_W | Stored debug/mode word |
| xfer_bytes | output | CNT_W | Transfer byte counter |
| sts_set | input | 11 | Per-bit status set from the engines |
| rsp_load | input | 1 | Response capture strobe |
| rsp_data | input | 4*DATA_W | Four response words |
| dport_wr | output | 1 | Data-port write pulse |
| dport_wdata | output | DATA_W | Data-port write word |
| dport_rd | output | 1 | Data-port read pulse |
| dport_rdata | input | DATA_W | Data-port read word |

## Verification
The bench builds the block with its defaults: 32-bit data, an 8-bit address, a 9-bit block count and a 32-bit counter. With these widths every mapped offset is reachable, and so are the unmapped gaps up to 0x5C. A block count of 0x1FF times a byte count with its top bit set makes the product overflow, so the truncation of the counter is exercised. Random configuration writes switch the three interrupt-enable gates on and off between random status sets and clears, so the gating and the one-cycle interrupt lag are checked in many combinations.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int NSEL = 15;
  localparam int SEL_CMD  = 0;
  localparam int SEL_ARG  = 1;
  localparam int SEL_TOUT = 2;
  localparam int SEL_CDIV = 3;
  localparam int SEL_RSP0 = 4;
  localparam int SEL_STS  = 8;
  localparam int SEL_PWR  = 9;
  localparam int SEL_MODE = 10;
  localparam int SEL_CFG  = 11;
  localparam int SEL_BCT  = 12;
  localparam int SEL_DATA = 13;
  localparam int SEL_BLK  = 14;
  localparam int NRSP     = 4;

  localparam int STS_W = 11;
  localparam int CFG_W = 11;
  localparam int CMD_W = 16;
  localparam int CMD_GO_BIT = 15;
  localparam int STS_BUSY  = 10;
  localparam int STS_BLOCK = 9;
  localparam int STS_DATA  = 8;
  localparam int CFG_BUSY_EN  = 10;
  localparam int CFG_BLOCK_EN = 8;
  localparam int CFG_DATA_EN  = 4;
  localparam logic [31:0] MODE_RST = 32'h0000_C60F;
  localparam int MODE_FSM_W = 4;

  // word index (byte offset / 4) of each selectable register
  function automatic int sel_word(input int s);
    case (s)
      SEL_PWR:  return 12;
      SEL_MODE: return 13;
      SEL_CFG:  return 14;
      SEL_BCT:  return 15;
      SEL_DATA: return 16;
      SEL_BLK:  return 20;
      default:  return s;
    endcase
  endfunction
endpackage

// File: rtl/sdh_decode.sv
module sdh_decode
  import sdh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_lsb;
  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = (32'(word) == sel_word(g));
  end
endmodule

// File: rtl/sdh_status.sv
module sdh_status
  import sdh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_wr,
  input  logic [STS_W-1:0] clr_mask,
  input  logic [STS_W-1:0] set_in,
  input  logic [CFG_W-1:0] cfg,
  output logic [STS_W-1:0] sts_q,
  output logic             irq
);
  logic [STS_W-1:0] gate, set_eff, clr_eff;

  always_comb begin
    gate = '1;
    gate[STS_BUSY]  = cfg[CFG_BUSY_EN];
    gate[STS_BLOCK] = cfg[CFG_BLOCK_EN];
    gate[STS_DATA]  = cfg[CFG_DATA_EN];
    set_eff = set_in & gate;
    clr_eff = clr_wr ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_eff) | set_eff;
      irq   <= sts_q[STS_BUSY] | sts_q[STS_BLOCK] | sts_q[STS_DATA];
    end
  end

  // R4: a clear with no concurrent set leaves the cleared bits at zero
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && set_in == '0) |=> ((sts_q & $past(clr_mask)) == '0));
  // R12: a gated busy bit cannot appear while its enable is off
  a_r12_busy_gate: assert property (@(posedge clk) disable iff (rst)
    (!sts_q[STS_BUSY] && !cfg[CFG_BUSY_EN]) |=> !sts_q[STS_BUSY]);
  // R5: the interrupt only follows an interrupt-class status bit
  a_r5_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(sts_q[STS_BUSY] | sts_q[STS_BLOCK] | sts_q[STS_DATA]));
endmodule

// File: rtl/sdh_xfer.sv
module sdh_xfer #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 9,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bct_wr,
  input  logic              blk_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bct_q,
  output logic [BLK_W-1:0]  blk_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam int PROD_W = DATA_W + BLK_W;

  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'(wdata[BLK_W-1:0]) * PROD_W'(bct_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bct_q <= '0;
      blk_q <= '0;
      cnt_q <= '0;
    end else begin
      if (bct_wr) bct_q <= wdata;
      if (blk_wr) begin
        blk_q <= wdata[BLK_W-1:0];
        cnt_q <= prod[CNT_W-1:0];
      end
    end
  end

  // R7: the counter stays put unless the block count is written
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !blk_wr |=> $stable(cnt_q));
endmodule

// File: rtl/sdh_regbank.sv
module sdh_regbank
  import sdh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 9,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_rvalid,
  output logic                   irq,
  output logic                   cmd_go,
  output logic [CMD_W-1:0]       cmd_word,
  output logic [DATA_W-1:0]      cmd_arg,
  output logic [CFG_W-1:0]       cfg_word,
  output logic                   pwr_on,
  output logic [DATA_W-1:0]      mode_word,
  output logic [CNT_W-1:0]       xfer_bytes,
  input  logic [STS_W-1:0]       sts_set,
  input  logic                   rsp_load,
  input  logic [NRSP*DATA_W-1:0] rsp_data,
  output logic                   dport_wr,
  output logic [DATA_W-1:0]      dport_wdata,
  output logic                   dport_rd,
  input  logic [DATA_W-1:0]      dport_rdata
);
  localparam logic [CMD_W-1:0] GO_MASK = CMD_W'(1) << CMD_GO_BIT;

  logic [NSEL-1:0]   sel, wsel;
  logic [STS_W-1:0]  sts_q;
  logic [DATA_W-1:0] bct_q;
  logic [BLK_W-1:0]  blk_q;
  logic [DATA_W-1:0] rsp_q [NRSP];
  logic [DATA_W-1:0] rd_mux;

  sdh_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  assign wsel = bus_wr ? sel : '0;

  sdh_status u_sts (
    .clk(clk), .rst(rst), .clr_wr(wsel[SEL_STS]),
    .clr_mask(bus_wdata[STS_W-1:0]), .set_in(sts_set), .cfg(cfg_word),
    .sts_q(sts_q), .irq(irq)
  );

  sdh_xfer #(.DATA_W(DATA_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst(rst), .bct_wr(wsel[SEL_BCT]), .blk_wr(wsel[SEL_BLK]),
    .wdata(bus_wdata), .bct_q(bct_q), .blk_q(blk_q), .cnt_q(xfer_bytes)
  );

  assign cmd_go      = wsel[SEL_CMD] & bus_wdata[CMD_GO_BIT];
  assign dport_wr    = wsel[SEL_DATA];
  assign dport_wdata = bus_wdata;
  assign dport_rd    = bus_rd & sel[SEL_DATA];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_word  <= '0;
      cmd_arg   <= '0;
      cfg_word  <= '0;
      pwr_on    <= 1'b0;
      mode_word <= DATA_W'(MODE_RST);
    end else begin
      if (wsel[SEL_CMD]) cmd_word <= bus_wdata[CMD_W-1:0] & ~GO_MASK;
      if (wsel[SEL_ARG]) cmd_arg  <= bus_wdata;
      if (wsel[SEL_CFG]) cfg_word <= bus_wdata[CFG_W-1:0];
      if (wsel[SEL_PWR]) pwr_on   <= bus_wdata[0];
      if (wsel[SEL_MODE]) begin
        if (&bus_wdata[MODE_FSM_W-1:0])
          mode_word <= {bus_wdata[DATA_W-1:MODE_FSM_W], {MODE_FSM_W{1'b0}}};
        else
          mode_word <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NRSP; g++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (rst)           rsp_q[g] <= '0;
      else if (rsp_load) rsp_q[g] <= rsp_data[g*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel[SEL_CMD])  rd_mux = DATA_W'(cmd_word);
    if (sel[SEL_ARG])  rd_mux = cmd_arg;
    if (sel[SEL_STS])  rd_mux = DATA_W'(sts_q);
    if (sel[SEL_PWR])  rd_mux = DATA_W'(pwr_on);
    if (sel[SEL_MODE]) rd_mux = mode_word;
    if (sel[SEL_CFG])  rd_mux = DATA_W'(cfg_word);
    if (sel[SEL_BCT])  rd_mux = bct_q;
    if (sel[SEL_BLK])  rd_mux = DATA_W'(blk_q);
    if (sel[SEL_DATA]) rd_mux = dport_rdata;
    for (int i = 0; i < NRSP; i++)
      if (sel[SEL_RSP0+i]) rd_mux = rsp_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  // R3: the stored command never holds the start bit
  a_r3_go_clear: assert property (@(posedge clk) disable iff (rst)
    wsel[SEL_CMD] |=> !cmd_word[CMD_GO_BIT]);
  // R6: an all-ones state field is stored as zero
  a_r6_mode_nibble: assert property (@(posedge clk) disable iff (rst)
    (wsel[SEL_MODE] && &bus_wdata[MODE_FSM_W-1:0]) |=> (mode_word[MODE_FSM_W-1:0] == '0));
  // R11: read data is valid exactly one cycle after a read
  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r11_rzero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
  // R8: ignored offsets leave the command argument untouched
  a_r8_ignored: assert property (@(posedge clk) disable iff (rst)
    (wsel[SEL_TOUT] || wsel[SEL_CDIV]) |=> $stable(cmd_arg) && $stable(cfg_word));
endmodule

// File: tb/sdh_regbank_test.sv
module sdh_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq, cmd_go, pwr_on, dport_wr, dport_rd;
  logic [15:0] cmd_word;
  logic [31:0] cmd_arg, mode_word, xfer_bytes, dport_wdata;
  logic [10:0] cfg_word;
  logic [10:0] sts_set = 0;
  logic        rsp_load = 0;
  logic [127:0] rsp_data = 0;
  logic [31:0] dport_rdata = 0;

  int n_checks = 0, n_err = 0;
  bit done = 0;

  logic [15:0] m_cmd;
  logic [31:0] m_arg, m_mode, m_bct, m_xfer;
  logic [10:0] m_cfg, m_sts;
  logic [8:0]  m_blk;
  logic        m_pwr;
  logic [31:0] m_rsp [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_regbank uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] dp);
    case (a[7:2])
      6'd0:  return {16'h0, m_cmd};
      6'd1:  return m_arg;
      6'd4, 6'd5, 6'd6, 6'd7: return m_rsp[a[3:2]];
      6'd8:  return {21'h0, m_sts};
      6'd12: return {31'h0, m_pwr};
      6'd13: return m_mode;
      6'd14: return {21'h0, m_cfg};
      6'd15: return m_bct;
      6'd16: return dp;
      6'd20: return {23'h0, m_blk};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [10:0] gated(input logic [10:0] s);
    logic [10:0] g = s;
    if (!m_cfg[10]) g[10] = 1'b0;
    if (!m_cfg[8])  g[9]  = 1'b0;
    if (!m_cfg[4])  g[8]  = 1'b0;
    return g;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a[7:2])
      6'd0:  m_cmd = d[15:0] & 16'h7FFF;
      6'd1:  m_arg = d;
      6'd8:  m_sts = m_sts & ~d[10:0];
      6'd12: m_pwr = d[0];
      6'd13: m_mode = (d[3:0] == 4'hF) ? {d[31:4], 4'h0} : d;
      6'd14: m_cfg = d[10:0];
      6'd15: m_bct = d;
      6'd20: begin m_blk = d[8:0]; m_xfer = 32'(d[8:0]) * m_bct; end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1;
    chk("R3 cmd_go", {31'h0, cmd_go}, {31'h0, (a[7:2] == 6'd0) && d[15]});
    chk("R9 dport_wr", {31'h0, dport_wr}, {31'h0, a[7:2] == 6'd16});
    if (a[7:2] == 6'd16) chk("R9 dport_wdata", dport_wdata, d);
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
    chk("R7 xfer_bytes", xfer_bytes, m_xfer);
    chk("R3 cmd_word", {16'h0, cmd_word}, {16'h0, m_cmd});
    chk("R6 mode_word", mode_word, m_mode);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    logic [31:0] dp;
    @(negedge clk);
    dp = $urandom;
    bus_rd = 1; bus_addr = a; dport_rdata = dp;
    #1;
    chk("R9 dport_rd", {31'h0, dport_rd}, {31'h0, a[7:2] == 6'd16});
    @(negedge clk);
    bus_rd = 0;
    chk("R11 rvalid", {31'h0, bus_rvalid}, 32'h1);
    chk(req, bus_rdata, exp_read(a, dp));
    #1;
    @(negedge clk);
    chk("R11 idle rdata", bus_rdata, 32'h0);
    chk("R11 idle rvalid", {31'h0, bus_rvalid}, 32'h0);
  endtask

  task automatic set_sts(input logic [10:0] s);
    @(negedge clk);
    sts_set = s;
    @(negedge clk);
    sts_set = 0;
    m_sts = m_sts | gated(s);
  endtask

  task automatic chk_irq;
    @(negedge clk);
    chk("R5 irq", {31'h0, irq}, {31'h0, |m_sts[10:8]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D1C_0A77));
    m_cmd = 0; m_arg = 0; m_mode = 32'h0000C60F; m_bct = 0; m_xfer = 0;
    m_cfg = 0; m_sts = 0; m_blk = 0; m_pwr = 0;
    for (int i = 0; i < 4; i++) m_rsp[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 xfer", xfer_bytes, 32'h0);
    chk("R1 cmd_go", {31'h0, cmd_go}, 32'h0);
    for (int a = 0; a < 24; a++) if (a != 16) rd(8'(a*4), "R1 reset read");

    // R2 readback of plain registers
    wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, "R2 arg");
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, "R2 power");
    chk("R2 pwr_on", {31'h0, pwr_on}, 32'h1);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, "R2 block count width");

    // R3 command start bit
    wr(8'h00, 32'h0001_80C5); rd(8'h00, "R3 cmd readback");
    wr(8'h00, 32'h0000_0452); rd(8'h00, "R3 cmd no start");

    // R6 mode nibble
    wr(8'h34, 32'h1234_567F); rd(8'h34, "R6 nibble F");
    wr(8'h34, 32'h1234_567E); rd(8'h34, "R6 nibble E");

    // R7 product and truncation, and no recompute on byte-count write
    wr(8'h3C, 32'h8000_0001); wr(8'h50, 32'h0000_01FF);
    chk("R7 truncated", xfer_bytes, 32'h8000_01FF);
    wr(8'h3C, 32'h0000_0200);
    chk("R7 hold after bct", xfer_bytes, 32'h8000_01FF);
    wr(8'h50, 32'h0000_0003);
    chk("R7 product", xfer_bytes, 32'h0000_0600);

    // R8 ignored offsets
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h08, "R8 timeout"); rd(8'h0C, "R8 cdiv"); rd(8'h44, "R8 unmapped");
    rd(8'h10, "R8 rsp not writable"); rd(8'h04, "R8 arg untouched");

    // R12 gating and R5 irq lag
    wr(8'h38, 32'h0); set_sts(11'h7FF);
    rd(8'h20, "R12 gated set"); chk_irq();
    wr(8'h38, 32'h0000_0400); set_sts(11'h400);
    chk("R5 irq lag", {31'h0, irq}, 32'h0);
    chk_irq();
    // R4 set wins over a same-cycle clear
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'h0000_0408; sts_set = 11'h008;
    @(negedge clk);
    bus_wr = 0; sts_set = 0;
    m_sts = (m_sts & ~11'h408) | 11'h008;
    rd(8'h20, "R4 set beats clear"); chk_irq();

    // R10 response capture
    @(negedge clk);
    rsp_data = {32'h4444_0003, 32'h3333_0002, 32'h2222_0001, 32'h1111_0000};
    rsp_load = 1;
    @(negedge clk);
    rsp_load = 0;
    m_rsp[0] = 32'h1111_0000; m_rsp[1] = 32'h2222_0001;
    m_rsp[2] = 32'h3333_0002; m_rsp[3] = 32'h4444_0003;
    for (int i = 0; i < 4; i++) rd(8'(8'h10 + i*4), "R10 response");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a = 8'($urandom_range(0, 23) * 4);
      if (op < 4) wr(a, $urandom);
      else if (op < 7) rd(a, "R2 R4 R8 random read");
      else if (op < 9) set_sts(11'($urandom));
      else begin
        @(negedge clk);
        rsp_data = {$urandom, $urandom, $urandom, $urandom};
        rsp_load = 1;
        @(negedge clk);
        rsp_load = 0;
        for (int i = 0; i < 4; i++) m_rsp[i] = rsp_data[i*32 +: 32];
      end
      chk_irq();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule